// File: doc/BRIEF.md
# Parity-Checked Two-Wire Frame Engine

This block is the bit-level master of a two-wire register bus. It owns a clock line (push-pull) and a shared data line (open drain: the engine either pulls it low or lets it float high). A client presents one request: an 8-bit command code, an 8-bit runtime address of the target, an 8-bit register address, a 12-bit hardware address (used only when assigning a runtime address) and up to 32 bits of write data. The engine turns the request into a frame on the wire and reports the outcome.

The transfer width and direction come from the command code. A register read is a single frame: the command, the runtime address and the register address go out, and the slave answers with the data in the same frame. No write phase comes before it. Instead of an acknowledge after each byte, every byte in either direction is followed by an odd parity bit. Only frames that the master completes with data of its own (writes and runtime-address assignment) end with one acknowledge slot from the slave. Reads end with no acknowledge at all.

The engine advances only on a bit-rate enable pulse supplied from outside. Two pulses make one bit: the first drops the clock and presents the bit, the second raises the clock, at which edge the bit is valid. An abort input stops any frame at once.

Top module: `tw_frame_engine`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, the clock output is high, the data line is not pulled, and busy and done are low.
- R2: Accepted command codes are 0x8B/0x9C/0xA6 (read 1/2/4 bytes), 0x4E/0x59/0x63 (write 1/2/4 bytes) and 0xE8 (assign runtime address). A request with any other code, or with runtime address 0, is dropped: busy stays low.
- R3: Each frame opens with a start condition: the data line falls while the clock is high, before the clock first goes low.
- R4: Bits are sent most significant first; the data line changes only while the clock is low and holds while it is high. Every byte is followed by one parity bit chosen so that the nine bits hold an odd count of ones.
- R5: A write frame carries the command, runtime address, register address, then the data bytes least significant byte first, then one slot where the master releases the line; a low level there is an acknowledge, a high level sets ack_err.
- R6: A read frame carries the command, runtime address and register address, after which the master releases the line for the data bytes; the first received byte lands in rdata[7:0], the next in rdata[15:8] and so on, unread bytes read as zero, and no acknowledge slot follows.
- R7: On reads, data_err bit i is set when the parity bit received after byte i does not give an odd count of ones; bits for bytes that are not read stay zero.
- R8: A runtime-address frame carries 0xE8, then {4'b0000, hw_addr[11:8]}, then hw_addr[7:0], then the runtime address, then an acknowledge slot as in R5.
- R9: Each frame closes with a stop condition (data line rises while the clock is high); done is high for exactly one clock, in the cycle busy falls, and rdata, data_err and ack_err hold their results from then on.
- R10: A request made while a frame is in progress is ignored; the frame on the wire is unchanged.
- R11: When abort is high at a clock edge, busy is low after that edge, both lines are released high, and the aborted frame never signals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable pulse, two per bit on the wire |
| abort | input | 1 | Stop the current frame and release the lines |
| req | input | 1 | Request strobe, taken when idle |
| cmd | input | 8 | Command code |
| rt_addr | input | 8 | Runtime address of the target (non-zero) |
| reg_addr | input | 8 | Register address |
| hw_addr | input | 12 | Hardware address for runtime-address assignment |
| wdata | input | 32 | Write data, least significant byte sent first |
| sda_i | input | 1 | Level seen on the data line |
| scl | output | 1 | Clock line |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| ack_err | output | 1 | Acknowledge slot read high |
| data_err | output | 4 | Per-byte read parity failure |
| rdata | output | 32 | Read data |

## Verification
A request is taken at the clock edge where it is seen, and a rejected or ignored request shows as busy still low (or the frame unchanged) one cycle later. Wire bits are due at each rising clock line, which comes one enable pulse after the falling one; the bench's slave model samples the line at the negative clock edge in the cycle the clock output rises and drives its own bits in the cycle the clock output falls. Done rises in the cycle of the third stop tick, with the read data and error flags already valid; the bench waits for that pulse and then checks everything one cycle later, when done must also have dropped. Abort takes effect at the very next edge, so its checks sample at the negative edge after the abort pulse.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 4;
    localparam int DATA_W     = BYTE_W * MAX_BYTES;
    localparam int HW_ADDR_W  = 12;
    localparam int IDX_W      = 4;
    localparam int BCNT_W     = 4;
    localparam int NB_W       = 3;

    localparam logic [7:0] CMD_RD8   = 8'h8B;
    localparam logic [7:0] CMD_RD16  = 8'h9C;
    localparam logic [7:0] CMD_RD32  = 8'hA6;
    localparam logic [7:0] CMD_WR8   = 8'h4E;
    localparam logic [7:0] CMD_WR16  = 8'h59;
    localparam logic [7:0] CMD_WR32  = 8'h63;
    localparam logic [7:0] CMD_SETRT = 8'hE8;

    typedef enum logic [2:0] {
        SYM_START,
        SYM_TX,
        SYM_RX,
        SYM_ACK,
        SYM_STOP
    } sym_kind_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_SETRT
    } op_e;

    typedef struct packed {
        op_e            op;
        logic [NB_W-1:0] nbytes;
    } cmd_info_t;

    typedef struct packed {
        sym_kind_e   kind;
        logic [7:0]  val;
        logic [1:0]  lane;
    } sym_t;

    // Parity bit that makes nine bits carry an odd count of ones
    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    function automatic cmd_info_t decode_cmd(input logic [7:0] c);
        cmd_info_t r;
        r.op     = OP_NONE;
        r.nbytes = '0;
        case (c)
            CMD_RD8:   begin r.op = OP_READ;  r.nbytes = 3'd1; end
            CMD_RD16:  begin r.op = OP_READ;  r.nbytes = 3'd2; end
            CMD_RD32:  begin r.op = OP_READ;  r.nbytes = 3'd4; end
            CMD_WR8:   begin r.op = OP_WRITE; r.nbytes = 3'd1; end
            CMD_WR16:  begin r.op = OP_WRITE; r.nbytes = 3'd2; end
            CMD_WR32:  begin r.op = OP_WRITE; r.nbytes = 3'd4; end
            CMD_SETRT: begin r.op = OP_SETRT; r.nbytes = 3'd0; end
            default:   begin r.op = OP_NONE;  r.nbytes = 3'd0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tw_sym_gen.sv
// Maps a symbol index within the frame to what goes on the wire at that slot.
module tw_sym_gen
    import tw_pkg::*;
(
    input  cmd_info_t              info,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             cmd,
    input  logic [7:0]             rt_addr,
    input  logic [7:0]             reg_addr,
    input  logic [HW_ADDR_W-1:0]   hw_addr,
    input  logic [DATA_W-1:0]      wdata,
    output sym_t                   sym
);
    logic [IDX_W-1:0] data_idx;
    logic             in_data;
    logic             at_ack;

    assign data_idx = idx - IDX_W'(4);
    assign in_data  = ({1'b0, idx} < (5'd4 + {2'b00, info.nbytes}));
    assign at_ack   = ({1'b0, idx} == (5'd4 + {2'b00, info.nbytes}));

    always_comb begin
        sym.kind = SYM_STOP;
        sym.val  = '0;
        sym.lane = '0;
        if (idx == IDX_W'(0)) begin
            sym.kind = SYM_START;
        end else if (idx == IDX_W'(1)) begin
            sym.kind = SYM_TX;
            sym.val  = cmd;
        end else if (info.op == OP_SETRT) begin
            case (idx)
                IDX_W'(2): begin sym.kind = SYM_TX; sym.val = {4'b0000, hw_addr[11:8]}; end
                IDX_W'(3): begin sym.kind = SYM_TX; sym.val = hw_addr[7:0]; end
                IDX_W'(4): begin sym.kind = SYM_TX; sym.val = rt_addr; end
                IDX_W'(5): sym.kind = SYM_ACK;
                default:   sym.kind = SYM_STOP;
            endcase
        end else if (idx == IDX_W'(2)) begin
            sym.kind = SYM_TX;
            sym.val  = rt_addr;
        end else if (idx == IDX_W'(3)) begin
            sym.kind = SYM_TX;
            sym.val  = reg_addr;
        end else if (in_data) begin
            sym.lane = data_idx[1:0];
            if (info.op == OP_READ) begin
                sym.kind = SYM_RX;
            end else begin
                sym.kind = SYM_TX;
                sym.val  = wdata[{data_idx[1:0], 3'b000} +: 8];
            end
        end else if (at_ack && info.op == OP_WRITE) begin
            sym.kind = SYM_ACK;
        end
    end
endmodule

// File: rtl/tw_rx_lanes.sv
// Shared input shifter with one byte store and parity flag per lane.
module tw_rx_lanes
    import tw_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 sample,
    input  logic                 last,
    input  logic [LW-1:0]        lane,
    input  logic                 sda_i,
    output logic [LANES*8-1:0]   rdata,
    output logic [LANES-1:0]     err
);
    logic [7:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q <= '0;
        end else if (sample && !last) begin
            sh_q <= {sh_q[6:0], sda_i};
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       err_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                byte_q <= '0;
                err_q  <= 1'b0;
            end else if (sample && last && lane == LW'(g)) begin
                byte_q <= sh_q;
                err_q  <= (sda_i != odd_par(sh_q));
            end
        end
        assign rdata[g*8 +: 8] = byte_q;
        assign err[g]          = err_q;
    end

    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err == '0 && rdata == '0)); // R7
endmodule

// File: rtl/tw_frame_engine.sv
module tw_frame_engine
    import tw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic                  abort,
    input  logic                  req,
    input  logic [7:0]            cmd,
    input  logic [7:0]            rt_addr,
    input  logic [7:0]            reg_addr,
    input  logic [HW_ADDR_W-1:0]  hw_addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  sda_i,
    output logic                  scl,
    output logic                  sda_pull,
    output logic                  busy,
    output logic                  done,
    output logic                  ack_err,
    output logic [MAX_BYTES-1:0]  data_err,
    output logic [DATA_W-1:0]     rdata
);
    cmd_info_t              req_info, info_q;
    logic                   req_ok;
    logic [7:0]             cmd_q, rt_q, reg_q;
    logic [HW_ADDR_W-1:0]   hw_q;
    logic [DATA_W-1:0]      wd_q;
    logic                   busy_q, done_q, scl_q, pull_q, ack_err_q, ph_q;
    logic [IDX_W-1:0]       idx_q;
    logic [BCNT_W-1:0]      bcnt_q;
    sym_t                   sym;
    logic                   tick, last_bit, tx_bit, rx_sample;

    assign req_info = decode_cmd(cmd);
    assign req_ok   = req && !busy_q && (req_info.op != OP_NONE) && (rt_addr != 8'h00);

    tw_sym_gen u_sym (
        .info     (info_q),
        .idx      (idx_q),
        .cmd      (cmd_q),
        .rt_addr  (rt_q),
        .reg_addr (reg_q),
        .hw_addr  (hw_q),
        .wdata    (wd_q),
        .sym      (sym)
    );

    assign tick      = bit_en && busy_q;
    assign last_bit  = (bcnt_q == BCNT_W'(8));
    assign tx_bit    = last_bit ? odd_par(sym.val) : sym.val[~bcnt_q[2:0]];
    assign rx_sample = tick && ph_q && (sym.kind == SYM_RX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            scl_q     <= 1'b1;
            pull_q    <= 1'b0;
            ack_err_q <= 1'b0;
            ph_q      <= 1'b0;
            idx_q     <= '0;
            bcnt_q    <= '0;
            info_q    <= '0;
            cmd_q     <= '0;
            rt_q      <= '0;
            reg_q     <= '0;
            hw_q      <= '0;
            wd_q      <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
                scl_q  <= 1'b1;
                pull_q <= 1'b0;
                ph_q   <= 1'b0;
                idx_q  <= '0;
                bcnt_q <= '0;
            end else if (req_ok) begin
                busy_q    <= 1'b1;
                ack_err_q <= 1'b0;
                ph_q      <= 1'b0;
                idx_q     <= '0;
                bcnt_q    <= '0;
                info_q    <= req_info;
                cmd_q     <= cmd;
                rt_q      <= rt_addr;
                reg_q     <= reg_addr;
                hw_q      <= hw_addr;
                wd_q      <= wdata;
            end else if (tick) begin
                case (sym.kind)
                    SYM_START: begin
                        scl_q  <= 1'b1;
                        pull_q <= 1'b1;
                        idx_q  <= idx_q + IDX_W'(1);
                    end
                    SYM_TX, SYM_RX: begin
                        if (!ph_q) begin
                            scl_q  <= 1'b0;
                            pull_q <= (sym.kind == SYM_TX) ? !tx_bit : 1'b0;
                            ph_q   <= 1'b1;
                        end else begin
                            scl_q <= 1'b1;
                            ph_q  <= 1'b0;
                            if (last_bit) begin
                                bcnt_q <= '0;
                                idx_q  <= idx_q + IDX_W'(1);
                            end else begin
                                bcnt_q <= bcnt_q + BCNT_W'(1);
                            end
                        end
                    end
                    SYM_ACK: begin
                        if (!ph_q) begin
                            scl_q  <= 1'b0;
                            pull_q <= 1'b0;
                            ph_q   <= 1'b1;
                        end else begin
                            scl_q     <= 1'b1;
                            ph_q      <= 1'b0;
                            ack_err_q <= sda_i;
                            idx_q     <= idx_q + IDX_W'(1);
                        end
                    end
                    default: begin
                        case (bcnt_q)
                            BCNT_W'(0): begin
                                scl_q  <= 1'b0;
                                pull_q <= 1'b1;
                                bcnt_q <= BCNT_W'(1);
                            end
                            BCNT_W'(1): begin
                                scl_q  <= 1'b1;
                                bcnt_q <= BCNT_W'(2);
                            end
                            default: begin
                                pull_q <= 1'b0;
                                busy_q <= 1'b0;
                                done_q <= 1'b1;
                                bcnt_q <= '0;
                                idx_q  <= '0;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    tw_rx_lanes #(.LANES(MAX_BYTES)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clr    (req_ok),
        .sample (rx_sample),
        .last   (last_bit),
        .lane   (sym.lane),
        .sda_i  (sda_i),
        .rdata  (rdata),
        .err    (data_err)
    );

    assign scl      = scl_q;
    assign sda_pull = pull_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign ack_err  = ack_err_q;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (scl_q && !pull_q)); // R1

    AST_BAD_REQ_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (req && !busy_q && !abort && rt_addr == 8'h00) |=> !busy_q); // R2

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && scl_q && $past(scl_q)
         && (sym.kind inside {SYM_TX, SYM_RX, SYM_ACK})
         && $past(sym.kind) == sym.kind) |-> $stable(pull_q)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R9

    AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $fell(busy_q)); // R9

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy_q && scl_q && !pull_q && !done_q)); // R11
endmodule

// File: tb/test_tw_frame_engine.sv
module test_tw_frame_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        abort = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  cmd = '0, rt_addr = '0, reg_addr = '0;
    logic [11:0] hw_addr = '0;
    logic [31:0] wdata = '0;
    logic        sda_i;
    logic        scl, sda_pull, busy, done, ack_err;
    logic [3:0]  data_err;
    logic [31:0] rdata;

    logic slave_pull = 1'b0;
    assign sda_i = !(sda_pull || slave_pull);

    tw_frame_engine i_tw_frame_engine (
        .clk(clk), .rst(rst), .bit_en(bit_en), .abort(abort), .req(req),
        .cmd(cmd), .rt_addr(rt_addr), .reg_addr(reg_addr), .hw_addr(hw_addr),
        .wdata(wdata), .sda_i(sda_i), .scl(scl), .sda_pull(sda_pull),
        .busy(busy), .done(done), .ack_err(ack_err), .data_err(data_err),
        .rdata(rdata)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int div_cnt = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // bit-rate enable: one pulse every four clocks
    initial begin
        forever begin
            @(negedge clk);
            bit_en = (div_cnt == 3);
            div_cnt = (div_cnt + 1) % 4;
        end
    end

    // Behavioural slave/monitor: expected wire bits and which ones it drives
    logic exp_q[$];
    logic drv_q[$];
    logic obs_q[$];
    int   start_cnt = 0;
    int   stop_cnt = 0;
    logic scl_p = 1'b1;
    logic sda_p = 1'b1;

    always @(negedge clk) begin
        if (scl_p && scl && sda_p && !sda_i) begin
            start_cnt++;
            obs_q.delete();
        end else if (scl_p && scl && !sda_p && sda_i) begin
            stop_cnt++;
        end
        if (scl_p && !scl) begin
            int p;
            p = obs_q.size();
            slave_pull = (p < drv_q.size()) ? (drv_q[p] && !exp_q[p]) : 1'b0;
        end
        if (!scl_p && scl) obs_q.push_back(sda_i);
        scl_p = scl;
        sda_p = !(sda_pull || slave_pull);
    end

    task automatic push_byte(input logic [7:0] b, input bit by_slave, input bit flip);
        for (int i = 7; i >= 0; i--) begin
            exp_q.push_back(b[i]);
            drv_q.push_back(by_slave);
        end
        exp_q.push_back((($countones(b) % 2) == 0) ^ flip);
        drv_q.push_back(by_slave);
    endtask

    task automatic run_frame(input logic [7:0] c, input logic [7:0] rt, input logic [7:0] ra,
                             input logic [11:0] hw, input logic [31:0] wd, input logic [31:0] rd_val,
                             input logic [3:0] flip, input bit nack, input bit poke, input string tag);
        bit is_rd, is_wr, is_set;
        int nb, w, mism;
        bit seen;
        logic [31:0] mask;
        is_rd = 0; is_wr = 0; is_set = 0; nb = 0;
        case (c)
            8'h8B: begin is_rd = 1; nb = 1; end
            8'h9C: begin is_rd = 1; nb = 2; end
            8'hA6: begin is_rd = 1; nb = 4; end
            8'h4E: begin is_wr = 1; nb = 1; end
            8'h59: begin is_wr = 1; nb = 2; end
            8'h63: begin is_wr = 1; nb = 4; end
            default: is_set = 1;
        endcase
        exp_q.delete(); drv_q.delete();
        push_byte(c, 0, 0);
        if (is_set) begin
            push_byte({4'h0, hw[11:8]}, 0, 0);
            push_byte(hw[7:0], 0, 0);
            push_byte(rt, 0, 0);
        end else begin
            push_byte(rt, 0, 0);
            push_byte(ra, 0, 0);
            for (int i = 0; i < nb; i++) begin
                if (is_rd) push_byte(rd_val[8*i +: 8], 1, flip[i]);
                else       push_byte(wd[8*i +: 8], 0, 0);
            end
        end
        if (is_wr || is_set) begin
            exp_q.push_back(nack);
            drv_q.push_back(!nack);
        end
        exp_q.push_back(1'b0);   // clock rise inside the stop condition
        drv_q.push_back(1'b0);
        mask = '0;
        for (int i = 0; i < nb; i++) mask[8*i +: 8] = 8'hFF;

        start_cnt = 0; stop_cnt = 0;
        @(negedge clk);
        cmd = c; rt_addr = rt; reg_addr = ra; hw_addr = hw; wdata = wd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        w = 0; seen = 0;
        while (!seen && w < 5000) begin
            if (done) seen = 1;
            else begin
                @(negedge clk);
                w++;
                if (poke && w == 40) begin
                    cmd = 8'h4E; rt_addr = 8'h3A; wdata = 32'h0; req = 1'b1;
                end
                if (poke && w == 41) req = 1'b0;
            end
        end
        chk(seen, {tag, " R9 done pulse"}, 32'(seen), 1);
        @(negedge clk);
        chk(!done, {tag, " R9 done one cycle"}, 32'(done), 0);
        chk(start_cnt == 1, {tag, " R3 start count"}, start_cnt, 1);
        chk(stop_cnt == 1, {tag, " R9 stop count"}, stop_cnt, 1);
        chk(obs_q.size() == exp_q.size(), {tag, " R4 bit count"}, obs_q.size(), exp_q.size());
        mism = 0;
        for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
            if (obs_q[i] !== exp_q[i]) mism++;
        chk(mism == 0, {tag, poke ? " R10 frame bits" : " R4 frame bits"}, mism, 0);
        chk(ack_err == ((is_wr || is_set) ? nack : 1'b0), {tag, " R5 ack_err"}, 32'(ack_err), 32'(nack));
        chk(rdata == (is_rd ? (rd_val & mask) : 32'h0), {tag, " R6 rdata"}, rdata, rd_val & mask);
        chk(data_err == (is_rd ? (flip & 4'((1 << nb) - 1)) : 4'h0), {tag, " R7 data_err"},
            32'(data_err), 32'(flip));
        chk(!busy && scl && !sda_pull, {tag, " R1 idle after frame"}, {busy, scl, sda_pull}, 3'b010);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(scl && !sda_pull && !busy && !done, "R1 reset state", {scl, sda_pull, busy, done}, 4'b1000);

        // R2: unknown code and runtime address zero are dropped
        cmd = 8'h12; rt_addr = 8'h2D; req = 1'b1;
        @(negedge clk); req = 1'b0;
        @(negedge clk);
        chk(!busy, "R2 unknown code dropped", 32'(busy), 0);
        cmd = 8'h8B; rt_addr = 8'h00; req = 1'b1;
        @(negedge clk); req = 1'b0;
        @(negedge clk);
        chk(!busy && scl, "R2 runtime address zero dropped", 32'(busy), 0);

        run_frame(8'h4E, 8'h2D, 8'h10, 12'h0, 32'h0000_00A5, 32'h0, 4'h0, 0, 0, "wr8 R5");
        run_frame(8'h59, 8'h3A, 8'h81, 12'h0, 32'h0000_C3F0, 32'h0, 4'h0, 1, 0, "wr16 nack R5");
        run_frame(8'h63, 8'h4E, 8'hFF, 12'h0, 32'h1234_8001, 32'h0, 4'h0, 0, 0, "wr32 R5");
        run_frame(8'h8B, 8'h2D, 8'h03, 12'h0, 32'h0, 32'hDEAD_BE7F, 4'h0, 0, 0, "rd8 R6");
        run_frame(8'h9C, 8'h3A, 8'h20, 12'h0, 32'h0, 32'h0000_00FF, 4'h2, 0, 0, "rd16 R7");
        run_frame(8'hA6, 8'h4E, 8'h40, 12'h0, 32'h0, 32'h8142_7E00, 4'h5, 0, 0, "rd32 R7");
        run_frame(8'hE8, 8'h2D, 8'h00, 12'h3A3, 32'h0, 32'h0, 4'h0, 0, 0, "setrt R8");
        run_frame(8'hE8, 8'h4E, 8'h00, 12'hE89, 32'h0, 32'h0, 4'h0, 1, 0, "setrt nack R8");
        run_frame(8'h59, 8'h2D, 8'h55, 12'h0, 32'h0000_1122, 32'h0, 4'h0, 0, 1, "busy req R10");

        // R11: abort in the middle of a read
        cmd = 8'hA6; rt_addr = 8'h2D; reg_addr = 8'h01; req = 1'b1;
        exp_q.delete(); drv_q.delete();
        @(negedge clk); req = 1'b0;
        repeat (120) @(negedge clk);
        chk(busy, "R11 frame running before abort", 32'(busy), 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        slave_pull = 1'b0;
        chk(!busy && scl && !sda_pull, "R11 lines released after abort", {busy, scl, sda_pull}, 3'b010);
        seen = 0;
        repeat (300) begin
            @(negedge clk);
            if (done || busy) seen = 1;
        end
        chk(!seen, "R11 no done after abort", 32'(seen), 0);

        run_frame(8'h8B, 8'h3A, 8'h7E, 12'h0, 32'h0, 32'h0000_0000, 4'h1, 0, 0, "rd8 after abort R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule